// File: doc/BRIEF.md
# Restoring Shift-Subtract Divider

This block divides one N-bit integer by another over several clock cycles, one quotient bit per cycle, with N set by a parameter. A single working register carries the partial remainder in its upper part and collects quotient bits in its lower part. Each step first shifts that register left, then trial-subtracts the divisor from the upper part. A non-negative difference is kept and a 1 enters the quotient. A negative difference is discarded, which restores the old value, and a 0 enters the quotient. After the last step the upper part holds twice the true remainder and is shifted back right by one.

A caller presents the operands with a one-cycle `start` pulse while the block is idle, watches `busy`, and takes the results when the one-cycle `done` pulse appears. The results stay on the outputs until the next division completes. An input selects signed operation. In that mode the operands are reduced to magnitudes at start, and the stored signs correct the quotient and remainder during a final cycle. Division by zero is not trapped: it finishes like any other division and returns a fixed pattern.

Top module: `restoringDivider`

## Requirements
- R1: After reset `busy` and `done` are 0 and `quotient` and `remainder` are all zeros.
- R2: With `signedMode` = 0 and a nonzero divisor, the outputs satisfy dividend = quotient × divisor + remainder, with remainder < divisor, all treated as unsigned N-bit values.
- R3: A `start` taken at a rising edge while idle raises `busy` after that edge. `done` rises after the (N+2)th rising edge, counting the accepting edge as the first.
- R4: `done` is high for exactly one cycle, and `busy` is 0 whenever `done` is 1.
- R5: A `start` pulse that arrives while `busy` is 1 is ignored: the running division finishes with its original operands and latency.
- R6: `quotient` and `remainder` change only at the edge that raises `done`, and hold their values until the next completion.
- R7: With `signedMode` = 0 and a zero divisor, the quotient is all ones and the remainder equals the dividend.
- R8: With `signedMode` = 1, the operands are two's complement. The quotient is the magnitude quotient, negated when the operand signs differ. The remainder has the magnitude remainder's size and the dividend's sign. For example, at N = 4, -7 ÷ 2 gives -3 remainder -1.
- R9: In signed mode the same magnitude rule also covers the corner cases, and the result keeps the low N bits. The most negative value ÷ -1 returns the most negative value with remainder 0. A zero divisor returns quotient all ones for a non-negative dividend, quotient 1 for a negative dividend, and the dividend as remainder.
- R10: Operands and `signedMode` are sampled only at the accepting edge; changing them while `busy` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| signedMode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | WIDTH | Dividend operand |
| divisor | input | WIDTH | Divisor operand |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | WIDTH | Quotient of the last completed division |
| remainder | output | WIDTH | Remainder of the last completed division |

## Verification
A wrong quotient bit decision, a lost carry bit in the partial remainder, or a miscounted step only appears at the ports once `done` rises, N+2 cycles after start. There it shows as a quotient or remainder that breaks the division identity for some operand pair. Sweeping every operand pair in both modes at a small width therefore exposes any such fault within one division of the pair that triggers it. A controller fault shows sooner and more directly: the latency changes, `done` is held longer than one cycle, or `busy` overlaps `done`.

// File: rtl/divPkg.sv
package divPkg;

  // Strobes from the sequencer to the datapath, at most one high per cycle
  typedef struct packed {
    logic load;    // capture operands and perform the initial shift
    logic step;    // one trial-subtract and shift
    logic finish;  // undo the extra shift, apply signs, update outputs
  } divStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } divState_t;

endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output divStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  divState_t        state;
  logic [CNT_W-1:0] iterCnt;

  always_comb begin
    strobes.load   = (state == ST_IDLE) && start;
    strobes.step   = (state == ST_ITER);
    strobes.finish = (state == ST_FIX);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_ITER;
            iterCnt <= '0;
          end
        end
        ST_ITER: begin
          if (iterCnt == LAST_STEP) begin
            state <= ST_FIX;
          end else begin
            iterCnt <= iterCnt + 1'b1;
          end
        end
        ST_FIX: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R3
  finish_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> done);

  // R3
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    iterCnt < CNT_W'(WIDTH));

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobes_t      strobes,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  localparam int WORK_W = 2 * WIDTH + 1;  // extra top bit keeps the shifted-out carry
  localparam int DIFF_W = WIDTH + 2;      // upper part (N+1) plus a sign bit

  logic [WORK_W-1:0] workReg;
  logic [WIDTH-1:0]  divMag;
  logic              negQuot;
  logic              negRem;

  logic [WIDTH-1:0]  dividendMag;
  logic [WIDTH-1:0]  divisorMag;
  logic [WIDTH:0]    upperPart;
  logic [DIFF_W-1:0] trialDiff;
  logic              trialNeg;
  logic [WIDTH-1:0]  rawQuot;
  logic [WIDTH-1:0]  rawRem;

  always_comb begin
    dividendMag = (signedMode && dividend[WIDTH-1]) ? (~dividend + 1'b1) : dividend;
    divisorMag  = (signedMode && divisor[WIDTH-1])  ? (~divisor + 1'b1)  : divisor;
  end

  assign upperPart = workReg[WORK_W-1:WIDTH];
  assign trialDiff = {1'b0, upperPart} - {2'b00, divMag};
  assign trialNeg  = trialDiff[DIFF_W-1];
  assign rawQuot   = workReg[WIDTH-1:0];
  assign rawRem    = workReg[WORK_W-1:WIDTH+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workReg   <= '0;
      divMag    <= '0;
      negQuot   <= 1'b0;
      negRem    <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      if (strobes.load) begin
        workReg <= {{WIDTH{1'b0}}, dividendMag, 1'b0};
        divMag  <= divisorMag;
        negQuot <= signedMode && (dividend[WIDTH-1] ^ divisor[WIDTH-1]);
        negRem  <= signedMode && dividend[WIDTH-1];
      end else if (strobes.step) begin
        if (trialNeg) begin
          workReg <= {workReg[WORK_W-2:0], 1'b0};
        end else begin
          workReg <= {trialDiff[WIDTH-1:0], workReg[WIDTH-1:0], 1'b1};
        end
      end
      if (strobes.finish) begin
        quotient  <= negQuot ? (~rawQuot + 1'b1) : rawQuot;
        remainder <= negRem  ? (~rawRem + 1'b1)  : rawRem;
      end
    end
  end

  // R2
  partial_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && divMag != '0) |-> (upperPart < {divMag, 1'b0}));

  // R2
  kept_fit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !trialNeg) |-> !trialDiff[WIDTH]);

  // R7
  zero_div_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && divMag == '0) |=> workReg[0]);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> ($stable(quotient) && $stable(remainder)));

endmodule

// File: rtl/restoringDivider.sv
module restoringDivider
  import divPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  divStrobes_t strobes;

  divCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  divDatapath #(.WIDTH(WIDTH)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .signedMode (signedMode),
    .dividend   (dividend),
    .divisor    (divisor),
    .quotient   (quotient),
    .remainder  (remainder)
  );

endmodule

// File: tb/sim_restoringDivider.sv
`timescale 1ns/1ps
module sim_restoringDivider;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         signedMode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  restoringDivider #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic checkVal(input string tag, input string what,
                          input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  function automatic logic [W-1:0] neg4(input logic [W-1:0] x);
    return ~x + 1'b1;
  endfunction

  // Expected results from the requirement text (R2, R7, R8, R9)
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                       output logic [W-1:0] q, output logic [W-1:0] r);
    logic [W-1:0] ma, mb, uq, ur;
    ma = (s && a[W-1]) ? neg4(a) : a;
    mb = (s && b[W-1]) ? neg4(b) : b;
    if (mb == '0) begin
      uq = '1;
      ur = ma;
    end else begin
      uq = ma / mb;
      ur = ma % mb;
    end
    q = (s && (a[W-1] ^ b[W-1])) ? neg4(uq) : uq;
    r = (s && a[W-1]) ? neg4(ur) : ur;
  endtask

  task automatic runDiv(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic s, output int lat, output logic busyAfter);
    @(negedge clk);
    dividend = a;
    divisor = b;
    signedMode = s;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    busyAfter = busy;
    lat = 1;
    while (!done && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin : watchdog
    #(8 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : mainSeq
    int lat;
    logic bz;
    logic [W-1:0] eq, er, holdQ, holdR;
    string tag;

    #20;
    @(negedge clk);
    // R1 reset state
    checkVal("R1", "busy", busy, 0);
    checkVal("R1", "done", done, 0);
    checkVal("R1", "quotient", quotient, 0);
    checkVal("R1", "remainder", remainder, 0);
    rstN = 1'b1;

    // R2 worked example: 7 / 2 -> 3 r 1
    runDiv(4'd7, 4'd2, 1'b0, lat, bz);
    checkVal("R2", "7/2 quotient", quotient, 3);
    checkVal("R2", "7/2 remainder", remainder, 1);
    // R3 busy rises after the accepting edge, latency N+2
    checkVal("R3", "busy after start", bz, 1);
    checkVal("R3", "latency", lat, W + 2);
    // R4 busy low while done high, done one cycle
    checkVal("R4", "busy during done", busy, 0);
    @(negedge clk);
    checkVal("R4", "done drops", done, 0);

    // R8 example: -7 / 2 -> -3 r -1
    runDiv(4'b1001, 4'd2, 1'b1, lat, bz);
    checkVal("R8", "-7/2 quotient", quotient, 4'b1101);
    checkVal("R8", "-7/2 remainder", remainder, 4'b1111);

    // R9 most negative / -1
    runDiv(4'b1000, 4'b1111, 1'b1, lat, bz);
    checkVal("R9", "-8/-1 quotient", quotient, 4'b1000);
    checkVal("R9", "-8/-1 remainder", remainder, 0);

    // R7 unsigned divide by zero
    runDiv(4'd11, 4'd0, 1'b0, lat, bz);
    checkVal("R7", "x/0 quotient", quotient, 4'hF);
    checkVal("R7", "x/0 remainder", remainder, 11);

    // R5 and R10: restart attempt and operand changes while busy
    @(negedge clk);
    dividend = 4'd13;
    divisor = 4'd3;
    signedMode = 1'b0;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    dividend = 4'd2;
    divisor = 4'd1;
    signedMode = 1'b1;
    start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    dividend = 4'd9;
    lat = 4;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    checkVal("R5", "latency with ignored start", lat, W + 2);
    checkVal("R5", "quotient with ignored start", quotient, 4);
    checkVal("R10", "remainder after operand change", remainder, 1);

    // R6 outputs hold after completion despite input changes
    holdQ = quotient;
    holdR = remainder;
    divisor = 4'd7;
    dividend = 4'd6;
    repeat (5) @(negedge clk);
    checkVal("R6", "quotient held", quotient, holdQ);
    checkVal("R6", "remainder held", remainder, holdR);
    checkVal("R6", "no spurious done", done, 0);

    // Exhaustive sweep in both modes
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          runDiv(W'(a), W'(b), s[0], lat, bz);
          model(W'(a), W'(b), s[0], eq, er);
          if (s == 0) tag = (b == 0) ? "R7" : "R2";
          else if (b == 0 || (a == 8 && b == 15)) tag = "R9";
          else tag = "R8";
          checkVal(tag, $sformatf("q %0d/%0d s=%0d", a, b, s), quotient, eq);
          checkVal(tag, $sformatf("r %0d/%0d s=%0d", a, b, s), remainder, er);
          checkVal("R3", "sweep latency", lat, W + 2);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule